// File: doc/BRIEF.md
# Monitor Identification Stream Transmitter

This block lets a display hand its identification bytes to a graphics host over the two-wire monitor link. After reset it runs in a stream mode, where the host's vertical sync acts as a bit clock. Firmware loads bytes into a small queue. On each vsync rising edge the block moves one bit onto the open-drain data line. Each byte goes out most significant bit first, and a released null bit follows it as a packet separator.

When the host pulls its clock line low, the block leaves the stream mode and releases the data line. The host can then talk to the bus directly. If the clock line then stays high for a long run of vsync edges, the block drops back to the stream mode. Once the host completes a real addressed bus access, the block stays in the bus mode until firmware clears it. Queue level flags and a low-level interrupt let firmware refill the queue in batches.

Top module: `ddc_id_tx`

## Requirements
- R1: After reset the block is in stream mode (`bypass`=0), the data line is released (`sda_low`=0), `fifo_low`=1, `fifo_high`=0, `busy`=0, and no `fifo_irq` pulse occurs.
- R2: In stream mode each queued byte takes 9 vsync rising edges. The first 8 edges drive bit 7 down to bit 0, where `sda_low`=1 means the line carries 0. The ninth edge drives a released null bit (line reads 1). The line changes only on vsync rising edges.
- R3: In stream mode, a vsync edge that arrives with the queue empty and no byte in flight leaves the line released.
- R4: The queue holds 8 bytes and sends them in the order written. A write while 8 bytes are queued is dropped. `fifo_high`=1 exactly when 8 bytes are queued.
- R5: `fifo_low`=1 when fewer than N bytes are queued, with N = `low_sel` + 2 (00→2, 01→3, 10→4, 11→5).
- R6: `fifo_irq` is a one-cycle pulse in the cycle after `fifo_low` goes from 0 to 1.
- R7: A falling edge on `scl_in` in stream mode sets `bypass` one cycle later and releases the data line, which stays released in bypass mode. A byte in flight is abandoned.
- R8: `busy` reports `scl_in` low, delayed by one cycle.
- R9: In bypass mode without lock, the block returns to stream mode on the 128th vsync rising edge seen while `scl_in` is high. Any cycle with `scl_in` low restarts that count.
- R10: After a START (SDA falling while SCL is high), the 9th SCL rising edge is the acknowledge clock. If SDA is low on that edge while in bypass mode, the block locks and the timeout no longer returns it to stream mode. A not-acknowledged access does not lock.
- R11: `mode_clr` returns the block to stream mode on the next edge and clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Synchronized vertical sync used as the bit clock |
| scl_in | input | 1 | Synchronized host clock line level |
| sda_in | input | 1 | Synchronized data line level |
| fifo_wr | input | 1 | Queue write strobe |
| fifo_wdata | input | 8 | Byte to queue |
| low_sel | input | 2 | Low-level threshold select |
| mode_clr | input | 1 | Return to stream mode and drop the lock |
| sda_low | output | 1 | Pull the data line low when 1 |
| bypass | output | 1 | Bus (bypass) mode flag |
| busy | output | 1 | Host holds the clock line low |
| fifo_low | output | 1 | Queue below the selected threshold |
| fifo_high | output | 1 | Queue full |
| fifo_irq | output | 1 | One-cycle pulse when the low flag rises |

## Verification
A corrupted bit counter or shift register shows up at the data line on the very next vsync edge as a wrong bit or a misplaced null bit. A bench that compares every vsync-clocked bit against the expected frame catches it within one packet. Pointer or occupancy faults change the flags in the write cycle, and they reorder or drop bytes in the stream. A wrong idle counter or lock state only shows after the full 128-edge window, so the bench runs the window right up to the boundary and checks one edge short of it and exactly at it.

// File: rtl/ddc_id_tx.sv
module ddc_id_tx #(
  parameter int DW      = 8,
  parameter int DEPTH   = 8,
  parameter int IDLE_VS = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          fifo_wr,
  input  logic [DW-1:0] fifo_wdata,
  input  logic [1:0]    low_sel,
  input  logic          mode_clr,
  output logic          sda_low,
  output logic          bypass,
  output logic          busy,
  output logic          fifo_low,
  output logic          fifo_high,
  output logic          fifo_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1) + 1;
  localparam int BW = $clog2(DW + 1);
  localparam int TW = (IDLE_VS > 1) ? $clog2(IDLE_VS) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          vs_q, scl_q, sda_q, low_q;
  logic          active, locked, armed;
  logic [BW-1:0] bit_cnt, acnt;
  logic [DW-1:0] shreg;
  logic [TW-1:0] idle;

  wire vs_rise  = vsync & ~vs_q;
  wire scl_fall = scl_q & ~scl_in;
  wire scl_rise = ~scl_q & scl_in;
  wire start_c  = scl_in & scl_q & sda_q & ~sda_in;
  wire stop_c   = scl_in & scl_q & ~sda_q & sda_in;
  wire tick     = vs_rise & scl_in & ~bypass;
  wire pop      = tick & ~active & (count != '0);
  wire push     = fifo_wr & (count != CW'(DEPTH));
  wire ack_ok   = armed & scl_rise & (acnt == BW'(DW)) & ~sda_in;

  assign fifo_low  = count < (CW'(low_sel) + CW'(2));
  assign fifo_high = count == CW'(DEPTH);
  assign fifo_irq  = fifo_low & ~low_q;
  assign busy      = ~scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      low_q <= 1'b1;
    end else begin
      vs_q  <= vsync;
      scl_q <= scl_in;
      sda_q <= sda_in;
      low_q <= fifo_low;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= fifo_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sda_low <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (bypass || scl_fall) begin
      active  <= 1'b0;
      sda_low <= 1'b0;
    end else if (tick) begin
      if (active) begin
        if (bit_cnt == BW'(DW)) begin
          sda_low <= 1'b0;
          active  <= 1'b0;
        end else begin
          sda_low <= ~shreg[DW-1];
          shreg   <= shreg << 1;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (count != '0) begin
        sda_low <= ~mem[rd_ptr][DW-1];
        shreg   <= mem[rd_ptr] << 1;
        bit_cnt <= BW'(1);
        active  <= 1'b1;
      end else begin
        sda_low <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      acnt  <= '0;
    end else if (start_c) begin
      armed <= 1'b1;
      acnt  <= '0;
    end else if (stop_c) begin
      armed <= 1'b0;
    end else if (armed && scl_rise) begin
      if (acnt == BW'(DW)) armed <= 1'b0;
      else                 acnt  <= acnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_clr) begin
      bypass <= 1'b0;
      locked <= 1'b0;
      idle   <= '0;
    end else if (!bypass) begin
      idle <= '0;
      if (scl_fall) bypass <= 1'b1;
    end else begin
      if (ack_ok) locked <= 1'b1;
      if (!scl_in) idle <= '0;
      else if (vs_rise) begin
        if (idle == TW'(IDLE_VS - 1)) begin
          if (!locked && !ack_ok) begin
            bypass <= 1'b0;
            idle   <= '0;
          end
        end else begin
          idle <= idle + 1'b1;
        end
      end
    end
  end

  // R7
  bypass_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !sda_low);
  // R7
  scl_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !bypass && !mode_clr) |=> bypass);
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_rise && !scl_fall) |=> $stable(sda_low));
  // R4
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R4
  full_not_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_high |-> !fifo_low);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_irq |=> !fifo_irq);
  // R11
  clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> !bypass);
  // R9
  idle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |=> (idle == '0) || bypass);
endmodule

// File: tb/sim_ddc_id_tx.sv
module sim_ddc_id_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0, scl = 1'b1, host_sda = 1'b1;
  logic fifo_wr = 1'b0, mode_clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] low_sel = 2'b00;
  logic sda_low, bypass, busy, fifo_low, fifo_high, fifo_irq;
  wire  sda_in = host_sda & ~sda_low;

  int checks = 0, failures = 0, irq_n = 0;
  bit exp_q[$];
  string mon_tag = "R2";
  event smp_ev;

  always #4 clk = ~clk;

  ddc_id_tx u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .scl_in(scl), .sda_in(sda_in),
    .fifo_wr(fifo_wr), .fifo_wdata(wdata), .low_sel(low_sel), .mode_clr(mode_clr),
    .sda_low(sda_low), .bypass(bypass), .busy(busy), .fifo_low(fifo_low),
    .fifo_high(fifo_high), .fifo_irq(fifo_irq)
  );

  always @(negedge clk) if (rst_n && fifo_irq) irq_n++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    exp_q.push_back(1'b1);
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); fifo_wr = 1'b1; wdata = b;
    @(negedge clk); fifo_wr = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); -> smp_ev;
    vsync = 1'b0;
    cyc(2);
  endtask

  task automatic vs_n(int n);
    for (int i = 0; i < n; i++) vs_pulse();
  endtask

  task automatic scl_bit(logic d);
    host_sda = d; cyc(2);
    scl = 1'b1; cyc(2);
    scl = 1'b0; cyc(2);
  endtask

  task automatic access(logic [7:0] addr, logic ack);
    host_sda = 1'b1; scl = 1'b1; cyc(2);
    host_sda = 1'b0; cyc(2);
    scl = 1'b0; cyc(2);
    for (int i = 7; i >= 0; i--) scl_bit(addr[i]);
    scl_bit(ack ? 1'b0 : 1'b1);
    host_sda = 1'b0; cyc(2);
    scl = 1'b1; cyc(2);
    host_sda = 1'b1; cyc(2);
  endtask

  // monitor: every sampled vsync edge pops one expected line level
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() != 0) chk(mon_tag, {31'b0, ~sda_low}, {31'b0, exp_q.pop_front()});
      else                   chk("R3", {31'b0, ~sda_low}, 32'd1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(4); rst_n = 1'b1; cyc(2);
    // R1 reset state
    chk("R1 bypass", bypass, 0); chk("R1 line", sda_low, 0);
    chk("R1 low", fifo_low, 1); chk("R1 high", fifo_high, 0);
    chk("R1 busy", busy, 0); chk("R1 irq", irq_n, 0);
    // R3 empty queue keeps the line released
    vs_n(2);
    // R5 thresholds
    wr(8'hA5); chk("R5 n2 c1", fifo_low, 1);
    wr(8'h3C); chk("R5 n2 c2", fifo_low, 0);
    irq_n = 0;
    @(negedge clk); low_sel = 2'b01; cyc(2);
    chk("R5 n3 c2", fifo_low, 1);
    chk("R6 irq on threshold", irq_n, 1);
    wr(8'hFF); wr(8'h00); wr(8'h81);
    @(negedge clk); low_sel = 2'b11; cyc(1);
    chk("R5 n5 c5", fifo_low, 0);
    @(negedge clk); low_sel = 2'b10; cyc(1);
    chk("R5 n4 c5", fifo_low, 0);
    // R4 fill and overflow
    wr(8'h7E); wr(8'h01);
    chk("R4 high c7", fifo_high, 0);
    wr(8'hC3);
    chk("R4 high c8", fifo_high, 1);
    wr(8'h55);
    chk("R4 high after drop", fifo_high, 1);
    expect_byte(8'hA5); expect_byte(8'h3C); expect_byte(8'hFF); expect_byte(8'h00);
    expect_byte(8'h81); expect_byte(8'h7E); expect_byte(8'h01); expect_byte(8'hC3);
    @(negedge clk); low_sel = 2'b00;
    irq_n = 0;
    vs_pulse();
    chk("R4 high after pop", fifo_high, 0);
    vs_n(71);
    chk("R2 all bits used", exp_q.size(), 0);
    chk("R6 irq during drain", irq_n, 1);
    chk("R5 empty low", fifo_low, 1);
    vs_n(2);
    // R7 abandon a byte in flight
    wr(8'h00);
    expect_byte(8'h00);
    vs_n(3);
    exp_q.delete();
    @(negedge clk); scl = 1'b0; cyc(1);
    chk("R7 bypass set", bypass, 1);
    chk("R7 line released", sda_low, 0);
    chk("R8 busy low scl", busy, 1);
    vs_n(3);
    @(negedge clk); scl = 1'b1; cyc(1);
    chk("R8 busy high scl", busy, 0);
    // R9 timeout restart and boundary
    vs_n(100);
    @(negedge clk); scl = 1'b0; cyc(2); scl = 1'b1; cyc(2);
    vs_n(127);
    chk("R9 one short", bypass, 1);
    vs_pulse();
    chk("R9 at 128", bypass, 0);
    vs_n(2);
    // R10 nack does not lock
    access(8'hA0, 1'b0);
    chk("R10 nack entered", bypass, 1);
    vs_n(128);
    chk("R10 nack reverts", bypass, 0);
    // R10 ack locks
    access(8'hA0, 1'b1);
    vs_n(200);
    chk("R10 locked", bypass, 1);
    // R11 clear
    @(negedge clk); mode_clr = 1'b1;
    @(negedge clk); mode_clr = 1'b0;
    chk("R11 cleared", bypass, 0);
    @(negedge clk); scl = 1'b0; cyc(2); scl = 1'b1; cyc(1);
    chk("R11 re-entered", bypass, 1);
    vs_n(128);
    chk("R11 lock dropped", bypass, 0);
    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule